// File: doc/BRIEF.md
# UART Transmit Engine

This block serialises 8-bit characters onto an asynchronous serial line. A one-character holding register takes writes from the host side. At a baud tick the character moves into a shift register, which sends it as a start bit, the data bits least significant first, an optional parity bit and a stop bit. Every bit lasts exactly one baud-tick period. The baud tick is an enable pulse that comes from outside the block.

Single-cycle command pulses enable the transmitter, disable it or reset it. A disable lets any character still held or shifting finish before the line goes quiet. A reset abandons everything at once. A parity selector chooses the parity bit for each character. Two status flags report when a new character can be written and when all activity has finished.

Top module: `uart_tx_engine`

## Requirements
- R1: After system reset the transmitter is disabled, with `tx_ready`=0, `tx_empty`=1 and `txd`=1, and writes have no effect until an enable command arrives.
- R2: An enabled transmitter with nothing to send holds `txd` at 1. A written character starts its start bit at the first baud tick after the write.
- R3: A disable command clears `tx_ready` on the next cycle. If the transmitter is idle it stops at once. Otherwise the character being shifted and the character in the holding register are both sent in full, and then the line stays idle.
- R4: A reset command stops the transmitter at once, even in the middle of a frame. From the next cycle `txd`=1, `tx_empty`=1 and `tx_ready`=0, and any held character is discarded.
- R5: A frame is one start bit at 0, then the 8 data bits least significant bit first, then the parity bit when one is selected, then one stop bit at 1. Each bit lasts one baud-tick period.
- R6: `parity_mode` encodes 0 = no parity bit, 1 = even (data plus parity has an even count of ones), 2 = odd, 3 = bit forced to 0, 4 = bit forced to 1, and 5 to 7 = no parity bit. The mode is sampled when the character moves into the shift register.
- R7: `tx_ready` is 1 exactly when the transmitter is enabled and the holding register is empty. An accepted write clears it on the next cycle. The transfer into the shift register at a baud tick sets it again on the next cycle.
- R8: `tx_empty` is 1 exactly when both the holding register and the shift register are empty. The line is at 1 whenever `tx_empty` is 1.
- R9: A write while `tx_ready`=0 is ignored and does not alter the character in flight or the one held.
- R10: If a character is held when a stop bit ends, the next start bit follows at once. Start bits of consecutive frames are then exactly one frame length of ticks apart.
- R11: Reset beats disable and enable in the same cycle, and disable beats enable.
- R12: `txd` changes only on the cycle after a baud tick or after a reset command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| cmd_enable | input | 1 | Enable pulse |
| cmd_disable | input | 1 | Disable pulse; pending characters drain first |
| cmd_reset | input | 1 | Immediate transmitter reset pulse |
| parity_mode | input | 3 | Parity selection, encoded as in R6 |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Nothing held and nothing shifting |
| txd | output | 1 | Serial output line |

## Verification
The assertions take for granted that `baud_tick` is a pulse of a single cycle separated by idle cycles. They also assume that `parity_mode` stays constant from a write until the character is loaded, and that command pulses last one cycle. The bench produces the tick from a free-running divide-by-4 counter. It drives every input only at the falling clock edge and changes the parity mode only while the transmitter is empty. A behavioural queue model predicts `txd`, `tx_ready` and `tx_empty` on every cycle, and a line decoder samples frames at mid-bit.

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 cmd_enable,
  input  logic                 cmd_disable,
  input  logic                 cmd_reset,
  input  logic [2:0]           parity_mode,
  input  logic                 wr_en,
  input  logic [DATA_BITS-1:0] wr_data,
  output logic                 tx_ready,
  output logic                 tx_empty,
  output logic                 txd
);
  localparam int FRAME_W = DATA_BITS + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic                 enabled;
  logic                 hold_full;
  logic [DATA_BITS-1:0] hold_q;
  logic                 busy;
  logic [FRAME_W-1:0]   shreg;
  logic [CNT_W-1:0]     bits_left;

  logic               par_on, par_bit, load, accept;
  logic [FRAME_W-1:0] frame_next;
  logic [CNT_W-1:0]   len_next;

  always_comb begin
    par_on  = 1'b1;
    par_bit = 1'b0;
    case (parity_mode)
      3'd1:    par_bit = ^hold_q;
      3'd2:    par_bit = ~^hold_q;
      3'd3:    par_bit = 1'b0;
      3'd4:    par_bit = 1'b1;
      default: par_on  = 1'b0;
    endcase
  end

  assign frame_next = par_on ? {1'b1, par_bit, hold_q, 1'b0} : {2'b11, hold_q, 1'b0};
  assign len_next   = par_on ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);

  assign load     = baud_tick && hold_full && (!busy || bits_left == CNT_W'(1));
  assign accept   = wr_en && tx_ready;
  assign tx_ready = enabled && !hold_full;
  assign tx_empty = !hold_full && !busy;
  assign txd      = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_reset) begin
      enabled   <= 1'b0;
      hold_full <= 1'b0;
      hold_q    <= '0;
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
    end else begin
      if (cmd_disable)     enabled <= 1'b0;
      else if (cmd_enable) enabled <= 1'b1;

      if (load) begin
        shreg     <= frame_next;
        bits_left <= len_next;
        busy      <= 1'b1;
      end else if (baud_tick && busy) begin
        shreg     <= {1'b1, shreg[FRAME_W-1:1]};
        bits_left <= bits_left - CNT_W'(1);
        if (bits_left == CNT_W'(1)) busy <= 1'b0;
      end

      if (accept) begin
        hold_full <= 1'b1;
        hold_q    <= wr_data;
      end else if (load) begin
        hold_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_tx_engine_props.sv
module uart_tx_engine_props #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 baud_tick,
  input logic                 cmd_enable,
  input logic                 cmd_disable,
  input logic                 cmd_reset,
  input logic [2:0]           parity_mode,
  input logic                 wr_en,
  input logic [DATA_BITS-1:0] wr_data,
  input logic                 tx_ready,
  input logic                 tx_empty,
  input logic                 txd
);
  p_idle_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  p_reset_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (tx_empty && !tx_ready && txd));

  p_disable_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_disable && !cmd_reset) |=> !tx_ready);

  p_accept_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_ready && !cmd_reset) |=> (!tx_ready && !tx_empty));

  p_ignored_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !cmd_reset && !baud_tick) |=> $stable(tx_empty));

  p_tick_paced_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !cmd_reset) |=> $stable(txd));
endmodule

bind uart_tx_engine uart_tx_engine_props #(.DATA_BITS(DATA_BITS)) u_props (.*);

// File: tb/uart_tx_engine_test.sv
`timescale 1ns/1ps
module uart_tx_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset = 1'b0;
  logic [2:0] parity_mode = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_ready, tx_empty, txd;

  int checks = 0;
  int failures = 0;
  longint cyc = 0;
  int tick_cnt = 0;

  always #4 clk = ~clk;

  uart_tx_engine uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tick_cnt  <= (tick_cnt + 1) % 4;
    baud_tick <= (tick_cnt == 3);
  end

  // behavioural reference model
  bit       m_en = 0, m_hv = 0;
  bit [7:0] m_hold = 0;
  bit       m_bits[$];

  always @(posedge clk) begin
    bit rdy, hv_old;
    rdy = m_en && !m_hv;
    hv_old = m_hv;
    if (!rst_n || cmd_reset) begin
      m_en = 0; m_hv = 0; m_bits.delete();
    end else begin
      if (baud_tick) begin
        if (m_bits.size() > 0) void'(m_bits.pop_front());
        if (m_bits.size() == 0 && hv_old) begin
          m_bits.push_back(1'b0);
          for (int i = 0; i < 8; i++) m_bits.push_back(m_hold[i]);
          case (parity_mode)
            3'd1: m_bits.push_back((^m_hold) ? 1'b1 : 1'b0);
            3'd2: m_bits.push_back((^m_hold) ? 1'b0 : 1'b1);
            3'd3: m_bits.push_back(1'b0);
            3'd4: m_bits.push_back(1'b1);
            default: ;
          endcase
          m_bits.push_back(1'b1);
          m_hv = 0;
        end
      end
      if (wr_en && rdy) begin m_hv = 1; m_hold = wr_data; end
      if (cmd_disable) m_en = 0; else if (cmd_enable) m_en = 1;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check(txd === ((m_bits.size() > 0) ? m_bits[0] : 1'b1), "R5", "model txd",
          txd, (m_bits.size() > 0) ? m_bits[0] : 1'b1);
    check(tx_ready === (m_en && !m_hv), "R7", "model tx_ready", tx_ready, m_en && !m_hv);
    check(tx_empty === (!m_hv && m_bits.size() == 0), "R8", "model tx_empty",
          tx_empty, !m_hv && m_bits.size() == 0);
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input bit en, input bit dis, input bit rs);
    @(negedge clk); cmd_enable = en; cmd_disable = dis; cmd_reset = rs;
    @(negedge clk); cmd_enable = 0; cmd_disable = 0; cmd_reset = 0;
  endtask

  task automatic wait_ready();
    do @(negedge clk); while (!tx_ready);
  endtask

  task automatic rx(input int nbits, output logic [10:0] bits, output longint t0);
    logic last;
    last = txd;
    forever begin
      @(negedge clk);
      if (txd == 1'b0 && last == 1'b1) break;
      last = txd;
    end
    t0 = cyc;
    bits = '1;
    repeat (2) @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < nbits; i++) begin
      repeat (4) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic [2:0] m);
    logic [10:0] f;
    logic p;
    case (m)
      3'd1: p = ^d;
      3'd2: p = ~^d;
      3'd3: p = 1'b0;
      3'd4: p = 1'b1;
      default: p = 1'b1;
    endcase
    f = {1'b1, p, d, 1'b0};
    if (m == 0 || m > 4) f[10] = 1'b1;
    return f;
  endfunction

  function automatic int flen(input logic [2:0] m);
    return (m >= 1 && m <= 4) ? 11 : 10;
  endfunction

  task automatic send_check(input logic [7:0] d, input logic [2:0] m, input string req);
    logic [10:0] got;
    longint t;
    @(negedge clk); parity_mode = m;
    fork
      write(d);
      rx(flen(m), got, t);
    join
    check(got === exp_frame(d, m), req, $sformatf("frame d=%0h mode=%0d", d, m),
          got, exp_frame(d, m));
    do @(negedge clk); while (!tx_empty);
  endtask

  initial begin
    logic [10:0] fa, fb;
    longint ta, tb;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ready === 1'b0, "R1", "ready after reset", tx_ready, 0);
    check(tx_empty === 1'b1, "R1", "empty after reset", tx_empty, 1);
    check(txd === 1'b1, "R1", "txd after reset", txd, 1);
    write(8'h3C);
    repeat (10) @(negedge clk);
    check(tx_empty === 1'b1 && txd === 1'b1, "R1", "write while disabled ignored", tx_empty, 1);

    pulse(1, 0, 0);
    check(tx_ready === 1'b1, "R7", "ready after enable", tx_ready, 1);
    repeat (12) @(negedge clk);
    check(txd === 1'b1, "R2", "idle line while enabled", txd, 1);

    send_check(8'hA5, 3'd0, "R5");
    send_check(8'h01, 3'd1, "R6");
    send_check(8'h03, 3'd1, "R6");
    send_check(8'h01, 3'd2, "R6");
    send_check(8'h07, 3'd2, "R6");
    send_check(8'hFF, 3'd3, "R6");
    send_check(8'h00, 3'd4, "R6");
    send_check(8'h5A, 3'd6, "R6");

    // back-to-back plus ignored write while full
    @(negedge clk); parity_mode = 3'd1;
    fork
      begin
        write(8'h11); wait_ready(); write(8'h22);
        write(8'h99);
      end
      begin rx(11, fa, ta); rx(11, fb, tb); end
    join
    check(fa === exp_frame(8'h11, 3'd1), "R10", "first frame", fa, exp_frame(8'h11, 3'd1));
    check(fb === exp_frame(8'h22, 3'd1), "R9", "second frame kept", fb, exp_frame(8'h22, 3'd1));
    check(tb - ta == 44, "R10", "start spacing", tb - ta, 44);
    do @(negedge clk); while (!tx_empty);

    // disable with drain
    @(negedge clk); parity_mode = 3'd0;
    fork
      begin write(8'h81); wait_ready(); write(8'h42); pulse(0, 1, 0);
            check(tx_ready === 1'b0, "R3", "ready drops on disable", tx_ready, 0); end
      begin rx(10, fa, ta); rx(10, fb, tb); end
    join
    check(fa === exp_frame(8'h81, 3'd0), "R3", "drain first", fa, exp_frame(8'h81, 3'd0));
    check(fb === exp_frame(8'h42, 3'd0), "R3", "drain second", fb, exp_frame(8'h42, 3'd0));
    repeat (6) @(negedge clk);
    check(tx_empty === 1'b1 && txd === 1'b1, "R3", "stopped after drain", tx_empty, 1);
    write(8'h77);
    repeat (10) @(negedge clk);
    check(tx_empty === 1'b1, "R9", "write after disable ignored", tx_empty, 1);

    // disable when idle
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    check(tx_ready === 1'b0, "R3", "idle disable immediate", tx_ready, 0);

    // priorities
    pulse(1, 1, 0);
    check(tx_ready === 1'b0, "R11", "disable beats enable", tx_ready, 0);
    pulse(1, 0, 1);
    check(tx_ready === 1'b0, "R11", "reset beats enable", tx_ready, 0);

    // reset mid-frame with a held character
    pulse(1, 0, 0);
    write(8'h00);
    do @(negedge clk); while (txd !== 1'b0);
    write(8'hF0);
    repeat (5) @(negedge clk);
    check(txd === 1'b0, "R4", "mid frame before reset", txd, 0);
    pulse(0, 0, 1);
    check(txd === 1'b1, "R4", "txd after reset cmd", txd, 1);
    check(tx_empty === 1'b1, "R4", "empty after reset cmd", tx_empty, 1);
    check(tx_ready === 1'b0, "R4", "ready after reset cmd", tx_ready, 0);
    repeat (30) @(negedge clk);
    check(txd === 1'b1 && tx_empty === 1'b1, "R4", "held char discarded", txd, 1);

    // R12 is covered by the per-cycle model compare against tick-aligned bits
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule